// File: doc/BRIEF.md
# Control-Register Instruction Executor

This unit carries out the six instructions that read and modify control and status registers. The three operations are swap, bit-set and bit-clear, and each comes in a register-operand form and a 5-bit immediate form. The registers live in a small file held inside the unit. The unit is given a 32-bit instruction word with a valid strobe and the value of the source integer register. One cycle later it returns a done pulse, the destination register index and value with a write-enable, and an illegal-instruction flag.

The operand fields decide whether a register access happens at all. A swap whose destination is x0 does not read the register. A set or clear whose source field is zero (register x0, or immediate 0) does not write it. A read strobe and a write strobe for each register come out in the done cycle, so that suppressed accesses can be seen at the ports.

The instruction input has no back-pressure. The unit takes a new instruction on every cycle in which the valid strobe is high, and the done pulse cannot be stalled. A caller that needs flow control keeps the strobe low.

Register k of the file, for k from 0 to NUM_CSR-2, sits at address RW_BASE+k. The last register sits at RO_ADDR. With the defaults, the addresses are 0x7C0, 0x7C1 and 0x7C2, and 0xFC0 for the read-only one. Register k resets to (k+1) times 0x0101…01. Its writable-bit mask depends on k mod 3: all ones for 0, 0x0F0F…0F for 1, and 0x0000FFFF repeated for 2.

Top module: `csr_exec_unit`

## Requirements
- R1: The unit accepts an instruction only when bits [6:0] = 1110011 and funct3 (bits [14:12]) is 001, 010, 011, 101, 110 or 111. Any other word with the valid strobe high is flagged illegal and has no other effect. Bits [31:20] hold the register address, bits [19:15] the source index or immediate, and bits [11:7] the destination.
- R2: done is high exactly one cycle after a cycle in which the valid strobe was high. In every other cycle, done, rd_we, illegal and all strobes are low.
- R3: Swap (funct3 x01) writes the mask to the register. The mask is src_value for the register form (bit 2 of funct3 is 0) and the zero-extended 5-bit immediate for the immediate form. When the destination is x0 there is no read strobe and rd_we stays low, but the write still takes place.
- R4: Set (funct3 x10) writes old OR mask, and writes only when the source field is non-zero.
- R5: Clear (funct3 x11) writes old AND NOT mask, and writes only when the source field is non-zero.
- R6: On a legal instruction, rd_data carries the old register value zero-extended, rd_idx carries the destination field, and rd_we is high only when the destination is non-zero.
- R7: Registers start at the reset values given above. A bit outside a register's writable mask keeps its value through every write.
- R8: Any access to an unimplemented address, and any write that would occur to an address whose bits [11:10] = 11, raises illegal. Such an instruction makes no register change, no rd_we and no strobes.
- R9: In the done cycle, csr_rd_stb and csr_wr_stb each have at most one bit set: the bit of the register addressed, set exactly when the read or the write takes place.
- R10: A read with no write (set or clear with a zero source field) of the register in the read-only space is legal and returns its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe, accepted every cycle |
| instr_word | input | 32 | Instruction word |
| src_value | input | XLEN | Value of the source integer register |
| done | output | 1 | Completion pulse, one cycle after the strobe |
| rd_we | output | 1 | Destination register write-enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Old register value, zero-extended |
| illegal | output | 1 | Illegal-instruction flag |
| csr_rd_stb | output | NUM_CSR | Read strobe for each register |
| csr_wr_stb | output | NUM_CSR | Write strobe for each register |

## Verification
A register that holds a wrong value is seen on the next instruction that addresses it, as a wrong rd_data in that instruction's done cycle. The sweep reads every register back after each batch of modifications, so such an error is caught within a few instructions. A wrong decision about whether a read or write happens shows up in the same done cycle as a wrong strobe or rd_we bit. Bits that are not writable but change anyway appear at the next readback, compared against the mask arithmetic that the bench computes itself.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

  localparam logic [6:0] SYSTEM_OPC = 7'b1110011;

  typedef enum logic [1:0] {
    OP_SWAP  = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11,
    OP_NONE  = 2'b00
  } csr_op_e;

  // Address of register slot i; the last slot lives in read-only space.
  function automatic logic [11:0] csr_addr_of(input int i, input int n,
                                              input logic [11:0] base,
                                              input logic [11:0] ro);
    if (i == n - 1) return ro;
    return base + 12'(i);
  endfunction

  function automatic logic [63:0] csr_reset_of(input int i);
    return 64'(i + 1) * 64'h0101_0101_0101_0101;
  endfunction

  function automatic logic [63:0] csr_wmask_of(input int i);
    case (i % 3)
      0:       return 64'hFFFF_FFFF_FFFF_FFFF;
      1:       return 64'h0F0F_0F0F_0F0F_0F0F;
      default: return 64'h0000_FFFF_0000_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_value,
  output csr_op_e         op,
  output logic            fmt_ok,
  output logic [11:0]     addr,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] mask,
  output logic            does_read,
  output logic            does_write,
  output logic            ro_space
);
  localparam int PADW = XLEN - 5;

  logic [2:0] f3;
  logic [4:0] src_fld;

  assign f3      = instr[14:12];
  assign src_fld = instr[19:15];
  assign addr    = instr[31:20];
  assign rd_idx  = instr[11:7];

  always_comb begin
    case (f3[1:0])
      2'b01:   op = OP_SWAP;
      2'b10:   op = OP_SET;
      2'b11:   op = OP_CLEAR;
      default: op = OP_NONE;
    endcase
    fmt_ok     = (instr[6:0] == SYSTEM_OPC) && (op != OP_NONE);
    mask       = f3[2] ? {{PADW{1'b0}}, src_fld} : src_value;
    does_read  = (op == OP_SWAP) ? (rd_idx != 5'd0) : 1'b1;
    does_write = (op == OP_SWAP) ? 1'b1 : (src_fld != 5'd0);
    ro_space   = (addr[11:10] == 2'b11);
  end
endmodule

// File: rtl/csr_reg_file.sv
module csr_reg_file
  import csr_exec_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          NUM_CSR = 4,
  parameter logic [11:0] RW_BASE = 12'h7C0,
  parameter logic [11:0] RO_ADDR = 12'hFC0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        addr,
  input  logic               wr_en,
  input  logic [XLEN-1:0]    wdata,
  output logic [NUM_CSR-1:0] hit,
  output logic               any_hit,
  output logic [XLEN-1:0]    rd_value
);
  logic [XLEN-1:0] q [NUM_CSR];

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_slot
    localparam logic [11:0]     ADDR = csr_addr_of(g, NUM_CSR, RW_BASE, RO_ADDR);
    localparam logic [XLEN-1:0] WM   = XLEN'(csr_wmask_of(g));
    localparam logic [XLEN-1:0] RV   = XLEN'(csr_reset_of(g));

    assign hit[g] = (addr == ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[g] <= RV;
      else if (wr_en && hit[g])
        q[g] <= (q[g] & ~WM) | (wdata & WM);
    end
  end

  assign any_hit = |hit;

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < NUM_CSR; i++)
      if (hit[i]) rd_value = rd_value | q[i];
  end
endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
  import csr_exec_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          NUM_CSR = 4,
  parameter logic [11:0] RW_BASE = 12'h7C0,
  parameter logic [11:0] RO_ADDR = 12'hFC0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [31:0]        instr_word,
  input  logic [XLEN-1:0]    src_value,
  output logic               done,
  output logic               rd_we,
  output logic [4:0]         rd_idx,
  output logic [XLEN-1:0]    rd_data,
  output logic               illegal,
  output logic [NUM_CSR-1:0] csr_rd_stb,
  output logic [NUM_CSR-1:0] csr_wr_stb
);
  csr_op_e            op;
  logic               fmt_ok, does_read, does_write, ro_space;
  logic [11:0]        addr;
  logic [4:0]         dst;
  logic [XLEN-1:0]    mask, old_val, new_val;
  logic [NUM_CSR-1:0] hit;
  logic               any_hit, bad, commit, wr_go;

  csr_op_decode #(.XLEN(XLEN)) u_dec (
    .instr      (instr_word),
    .src_value  (src_value),
    .op         (op),
    .fmt_ok     (fmt_ok),
    .addr       (addr),
    .rd_idx     (dst),
    .mask       (mask),
    .does_read  (does_read),
    .does_write (does_write),
    .ro_space   (ro_space)
  );

  csr_reg_file #(
    .XLEN(XLEN), .NUM_CSR(NUM_CSR), .RW_BASE(RW_BASE), .RO_ADDR(RO_ADDR)
  ) u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_go),
    .wdata    (new_val),
    .hit      (hit),
    .any_hit  (any_hit),
    .rd_value (old_val)
  );

  always_comb begin
    case (op)
      OP_SET:   new_val = old_val | mask;
      OP_CLEAR: new_val = old_val & ~mask;
      default:  new_val = mask;
    endcase
  end

  // Read-modify-write is resolved in one cycle: old value and commit share an edge.
  assign bad    = !fmt_ok || !any_hit || (does_write && ro_space);
  assign commit = instr_valid && !bad;
  assign wr_go  = commit && does_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      rd_we      <= 1'b0;
      rd_idx     <= '0;
      rd_data    <= '0;
      illegal    <= 1'b0;
      csr_rd_stb <= '0;
      csr_wr_stb <= '0;
    end else begin
      done       <= instr_valid;
      illegal    <= instr_valid && bad;
      rd_we      <= commit && (dst != 5'd0);
      rd_idx     <= instr_valid ? dst : 5'd0;
      rd_data    <= (commit && dst != 5'd0) ? old_val : '0;
      csr_rd_stb <= (commit && does_read) ? hit : '0;
      csr_wr_stb <= wr_go ? hit : '0;
    end
  end
endmodule

// File: rtl/csr_exec_chk.sv
module csr_exec_chk #(
  parameter int NUM_CSR = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic               done,
  input logic               rd_we,
  input logic [4:0]         rd_idx,
  input logic               illegal,
  input logic [NUM_CSR-1:0] csr_rd_stb,
  input logic [NUM_CSR-1:0] csr_wr_stb
);
  // R2
  done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> done);

  // R2
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!rd_we && !illegal && csr_rd_stb == '0 && csr_wr_stb == '0));

  // R9
  single_read_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(csr_rd_stb));

  // R9
  single_write_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(csr_wr_stb));

  // R8
  illegal_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rd_we && csr_rd_stb == '0 && csr_wr_stb == '0));

  // R6
  dest_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_idx != 5'd0));

  // R3
  dest_write_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (csr_rd_stb != '0));
endmodule

bind csr_exec_unit csr_exec_chk #(.NUM_CSR(NUM_CSR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .done        (done),
  .rd_we       (rd_we),
  .rd_idx      (rd_idx),
  .illegal     (illegal),
  .csr_rd_stb  (csr_rd_stb),
  .csr_wr_stb  (csr_wr_stb)
);

// File: tb/csr_exec_unit_bench.sv
`timescale 1ns/1ps
module csr_exec_unit_bench;
  localparam int XLEN = 32;
  localparam int NCSR = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [31:0]     instr_word = '0;
  logic [XLEN-1:0] src_value = '0;
  logic            done, rd_we, illegal;
  logic [4:0]      rd_idx;
  logic [XLEN-1:0] rd_data;
  logic [NCSR-1:0] csr_rd_stb, csr_wr_stb;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [NCSR];

  always #4 clk = ~clk;

  csr_exec_unit u_csr_exec_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .src_value(src_value), .done(done), .rd_we(rd_we), .rd_idx(rd_idx),
    .rd_data(rd_data), .illegal(illegal), .csr_rd_stb(csr_rd_stb),
    .csr_wr_stb(csr_wr_stb)
  );

  function automatic logic [11:0] t_addr(input int t);
    if (t == 3) return 12'hFC0;
    if (t == 4) return 12'h7C8;
    return 12'h7C0 + 12'(t);
  endfunction

  function automatic logic [31:0] t_wmask(input int t);
    if (t % 3 == 0) return 32'hFFFF_FFFF;
    if (t % 3 == 1) return 32'h0F0F_0F0F;
    return 32'h0000_FFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one instruction, check its done-cycle outputs, then update the model.
  task automatic issue(input logic [6:0] opc, input logic [2:0] f3, input int t,
                       input logic [4:0] rd, input logic [4:0] src,
                       input logic [31:0] rs1v);
    bit fmt, impl, ro, rdh, wrh, bad, imm;
    logic [31:0] msk, oldv, newv;
    logic [3:0] e_rs, e_ws;
    fmt  = (opc == 7'b1110011) && (f3[1:0] != 2'b00);
    impl = (t < 4);
    ro   = (t == 3);
    imm  = f3[2];
    rdh  = (f3[1:0] == 2'b01) ? (rd != 0) : 1'b1;
    wrh  = (f3[1:0] == 2'b01) ? 1'b1 : (src != 0);
    bad  = !fmt || !impl || (wrh && ro);
    msk  = imm ? {27'd0, src} : rs1v;
    oldv = impl ? model[t] : '0;
    case (f3[1:0])
      2'b10:   newv = oldv | msk;
      2'b11:   newv = oldv & ~msk;
      default: newv = msk;
    endcase
    e_rs = (!bad && rdh) ? (4'b1 << t) : 4'b0;
    e_ws = (!bad && wrh) ? (4'b1 << t) : 4'b0;

    @(negedge clk);
    instr_word  = {t_addr(t), src, f3, rd, opc};
    src_value   = rs1v;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(done == 1'b1, "R2 done pulse", 64'(done), 64'd1);
    chk(illegal == bad, "R8 illegal flag", 64'(illegal), 64'(bad));
    chk(rd_we == (!bad && rd != 0), "R6 rd_we", 64'(rd_we), 64'(!bad && rd != 0));
    if (!bad && rd != 0) begin
      chk(rd_data == oldv, "R6 old value", 64'(rd_data), 64'(oldv));
      chk(rd_idx == rd, "R6 rd_idx", 64'(rd_idx), 64'(rd));
    end
    chk(csr_rd_stb == e_rs, "R9 read strobe", 64'(csr_rd_stb), 64'(e_rs));
    chk(csr_wr_stb == e_ws, "R9 write strobe", 64'(csr_wr_stb), 64'(e_ws));
    if (!bad && wrh) model[t] = (oldv & ~t_wmask(t)) | (newv & t_wmask(t));
    @(negedge clk);
    chk(done == 1'b0 && rd_we == 1'b0 && csr_rd_stb == 0 && csr_wr_stb == 0,
        "R2 idle quiet", {62'd0, done, rd_we}, 64'd0);
  endtask

  // Read every implemented register back through csrrs with source x0 (R7, R10).
  task automatic readback_all();
    for (int t = 0; t < NCSR; t++) issue(7'b1110011, 3'b010, t, 5'd3, 5'd0, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < NCSR; t++) model[t] = 32'(t + 1) * 32'h0101_0101;
    repeat (3) @(negedge clk);
    chk(done == 0 && illegal == 0 && rd_we == 0, "R2 reset state",
        {61'd0, done, illegal, rd_we}, 64'd0);
    rst_n = 1'b1;

    // R7 reset values, R10 read of read-only space
    readback_all();

    // Sweep: R3 swap, R4 set, R5 clear, R8 illegal, R1 encodings
    for (int fi = 0; fi < 6; fi++) begin
      logic [2:0] f3;
      f3 = (fi < 3) ? 3'(fi + 1) : 3'(fi + 2);
      for (int t = 0; t < 5; t++)
        for (int r = 0; r < 2; r++)
          for (int s = 0; s < 2; s++) begin
            logic [31:0] pat;
            pat = 32'hDEAD_BEEF ^ (32'(fi * 20 + t * 4 + r * 2 + s) * 32'h0123_4567);
            issue(7'b1110011, f3, t, r ? 5'd7 : 5'd0, s ? 5'd9 : 5'd0, pat);
            if (t < 4) issue(7'b1110011, 3'b011, t, 5'd1, 5'd0, 32'h0);
          end
      readback_all();
    end

    // R1: funct3 000/100 and a foreign opcode are illegal with no effect
    issue(7'b1110011, 3'b000, 0, 5'd4, 5'd2, 32'hFFFF_FFFF);
    issue(7'b1110011, 3'b100, 1, 5'd4, 5'd2, 32'hFFFF_FFFF);
    issue(7'b0010011, 3'b001, 2, 5'd4, 5'd2, 32'hFFFF_FFFF);
    readback_all();

    // R7: all ones then all zeros into each writable slot, masked bits hold
    for (int t = 0; t < 3; t++) begin
      issue(7'b1110011, 3'b001, t, 5'd0, 5'd5, 32'hFFFF_FFFF);
      issue(7'b1110011, 3'b011, t, 5'd2, 5'd5, 32'hFFFF_FFFF);
    end
    readback_all();

    // R10 and R8: read-only slot, set with immediate 0 is legal, with 1 illegal
    issue(7'b1110011, 3'b110, 3, 5'd6, 5'd0, 32'h0);
    issue(7'b1110011, 3'b110, 3, 5'd6, 5'd1, 32'h0);
    readback_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule